// File: doc/BRIEF.md
# Clock output gating controller

This block decides, for every clock output channel of a clock generator, whether the channel runs, is held at a fixed driven level, or floats at high impedance. The channels fall into three groups: differential CPU pairs, differential SRC pairs and single-ended clocks. A small configuration store holds the per-channel settings. These are an enable bit per channel, a per-CPU-channel choice to obey or ignore the CPU stop input, a per-SRC-channel choice of which of two clock request inputs governs it and whether that request is honoured, and three drive-mode bits. The drive-mode bits say whether a stopped pair is driven or floated, separately for CPU stop and for power-down.

The stop input, the two request inputs and the power-down input are asynchronous. Each passes through a two-flop synchroniser. The block combines them with the configuration into a target state for every channel. A channel adopts its target state only in a cycle where that channel's falling-edge strobe is high, so a clock is always gated while it is low and no pulse is cut short. The per-channel outputs `run`, `stop level` and `high-impedance` feed the output buffers.

Top module: `clk_out_gate`

## Requirements
- R1: After reset every channel reports hiz=1, run=0, lvl=0 until its first strobe. The configuration resets as follows: all enables 1 except the 48 MHz single-ended channel (index SE_48M_IDX); every CPU stop-select bit 1; request-select, request-control and mode bits 0.
- R2: A channel whose enable bit is 0 floats (hiz=1, run=0, lvl=0) whatever the stop, request and power-down inputs are.
- R3: Request-select bit 0 routes an SRC channel to clk_req_n[0] and 1 routes it to clk_req_n[1]. When the request-control bit is 0, the request inputs have no effect on that channel.
- R4: A controlled SRC channel floats while its selected request input is high and runs while it is low.
- R5: When cpu_stop_n is low, a CPU channel whose stop-select bit is 1 stops and one whose bit is 0 keeps running. A stopped CPU channel is held driven high (run=0, hiz=0, lvl=1) when mode bit 0 is 1, and floats when it is 0.
- R6: While pwr_dn is high, every enabled single-ended channel is driven low (run=0, hiz=0, lvl=0). Enabled CPU channels are held high when mode bit 1 is 1 and float otherwise. Enabled SRC channels do the same under mode bit 2.
- R7: A channel's outputs change only in a cycle where its ch_fall strobe is high.
- R8: When the strobe is high in every cycle, a change on cpu_stop_n, clk_req_n or pwr_dn appears on the outputs after the third rising clock edge following the change and not earlier.
- R9: run and hiz are never both 1, lvl is 0 whenever hiz is 1, and channels resume running at their strobe once pwr_dn falls.
- R10: Configuration field codes are: 0 single-ended enables, 1 CPU enables, 2 SRC enables, 3 CPU stop-select, 4 request-select, 5 request-control, 6 mode. A write takes effect on the next rising edge, and a write with field code 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_field | input | 3 | Configuration field code (R10) |
| cfg_wdata | input | CFG_W | Configuration write data, LSB is channel 0 of the group |
| cpu_stop_n | input | 1 | Asynchronous CPU stop, active low |
| clk_req_n | input | 2 | Asynchronous clock request inputs, low requests the clock |
| pwr_dn | input | 1 | Asynchronous power-down, active high |
| ch_fall | input | N_CH | Per-channel strobe, high in a cycle where that channel's clock falls |
| ch_run | output | N_CH | Channel clock passes to its buffer |
| ch_stop_lvl | output | N_CH | Level held on the true leg when stopped and driven |
| ch_hiz | output | N_CH | Channel buffer at high impedance |

Channels are numbered CPU first, then SRC, then single-ended.

## Verification
A table of input patterns runs under a fixed routing set-up in which SRC0 and SRC2 follow request 0, SRC1 and SRC3 follow request 1, and CPU2 ignores stop. The patterns are: stop alone, each request alone, both requests with stop, and power-down under two drive modes. Together they separate a wrong request route from a wrong polarity, and a driven stop from a floated one. Directed cases then try the ignored field code and request-control at 0. They also try disabled channels under power-down, which separate float from drive-low, and count the exact edge at which a stop shows. Finally a strobe is withheld and then given to one channel only, which shows that the gating waits for each channel's own falling edge.

// File: rtl/clk_gate_pkg.sv
`timescale 1ns/1ps
package clk_gate_pkg;

    typedef enum logic [1:0] {
        CH_FLOAT   = 2'd0,
        CH_RUN     = 2'd1,
        CH_HOLD_LO = 2'd2,
        CH_HOLD_HI = 2'd3
    } ch_state_e;

    typedef enum logic [1:0] {
        KIND_CPU = 2'd0,
        KIND_SRC = 2'd1,
        KIND_SE  = 2'd2
    } ch_kind_e;

    typedef enum logic [2:0] {
        FLD_SE_EN    = 3'd0,
        FLD_CPU_EN   = 3'd1,
        FLD_SRC_EN   = 3'd2,
        FLD_STOP_SEL = 3'd3,
        FLD_REQ_SEL  = 3'd4,
        FLD_REQ_CTL  = 3'd5,
        FLD_MODE     = 3'd6,
        FLD_NONE     = 3'd7
    } cfg_field_e;

    // bit0 stop_drive, bit1 pd_cpu_drive, bit2 pd_src_drive
    typedef struct packed {
        logic pd_src_drive;
        logic pd_cpu_drive;
        logic stop_drive;
    } mode_t;

    // conditions seen by one channel
    typedef struct packed {
        logic en;
        logic pd;
        logic stop_hit;
        logic stop_drive;
        logic req_float;
        logic pd_drive;
    } ch_ctl_t;

    typedef struct packed {
        logic run;
        logic hiz;
        logic lvl;
    } ch_out_t;

    function automatic ch_state_e next_state(ch_kind_e kind, ch_ctl_t c);
        ch_state_e s;
        if (!c.en) begin
            s = CH_FLOAT;
        end else if (c.pd) begin
            if (kind == KIND_SE)  s = CH_HOLD_LO;
            else if (c.pd_drive)  s = CH_HOLD_HI;
            else                  s = CH_FLOAT;
        end else if (kind == KIND_CPU && c.stop_hit) begin
            s = c.stop_drive ? CH_HOLD_HI : CH_FLOAT;
        end else if (kind == KIND_SRC && c.req_float) begin
            s = CH_FLOAT;
        end else begin
            s = CH_RUN;
        end
        return s;
    endfunction

    function automatic ch_out_t state_out(ch_state_e s);
        ch_out_t o;
        o.run = (s == CH_RUN);
        o.hiz = (s == CH_FLOAT);
        o.lvl = (s == CH_HOLD_HI);
        return o;
    endfunction

endpackage

// File: rtl/clk_gate_sync.sv
`timescale 1ns/1ps
module clk_gate_sync #(
    parameter int            W       = 4,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;

    // R8: the synchronised value is the raw input two edges back
    a_r8_two_stage: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !$past(rst, 2) |-> (q_o == $past(d_i, 2)));
endmodule

// File: rtl/clk_gate_cfg.sv
`timescale 1ns/1ps
module clk_gate_cfg
    import clk_gate_pkg::*;
#(
    parameter int N_CPU      = 3,
    parameter int N_SRC      = 8,
    parameter int N_SE       = 4,
    parameter int SE_48M_IDX = 3,
    parameter int CFG_W      = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we_i,
    input  logic [2:0]       field_i,
    input  logic [CFG_W-1:0] wdata_i,
    output logic [N_SE-1:0]  se_en_o,
    output logic [N_CPU-1:0] cpu_en_o,
    output logic [N_SRC-1:0] src_en_o,
    output logic [N_CPU-1:0] stop_sel_o,
    output logic [N_SRC-1:0] req_sel_o,
    output logic [N_SRC-1:0] req_ctl_o,
    output mode_t            mode_o
);
    localparam logic [N_SE-1:0] SE_EN_RST = ~(N_SE'(1) << SE_48M_IDX);
    localparam int MODE_W = $bits(mode_t);

    cfg_field_e fld;
    assign fld = cfg_field_e'(field_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            se_en_o    <= SE_EN_RST;
            cpu_en_o   <= '1;
            src_en_o   <= '1;
            stop_sel_o <= '1;
            req_sel_o  <= '0;
            req_ctl_o  <= '0;
            mode_o     <= '0;
        end else if (we_i) begin
            unique case (fld)
                FLD_SE_EN:    se_en_o    <= wdata_i[N_SE-1:0];
                FLD_CPU_EN:   cpu_en_o   <= wdata_i[N_CPU-1:0];
                FLD_SRC_EN:   src_en_o   <= wdata_i[N_SRC-1:0];
                FLD_STOP_SEL: stop_sel_o <= wdata_i[N_CPU-1:0];
                FLD_REQ_SEL:  req_sel_o  <= wdata_i[N_SRC-1:0];
                FLD_REQ_CTL:  req_ctl_o  <= wdata_i[N_SRC-1:0];
                FLD_MODE:     mode_o     <= mode_t'(wdata_i[MODE_W-1:0]);
                FLD_NONE:     ;
            endcase
        end
    end

    // R10: the spare field code leaves every setting alone
    a_r10_spare_field: assert property (@(posedge clk) disable iff (rst)
        we_i && field_i == 3'd7 |=> $stable({se_en_o, cpu_en_o, src_en_o,
                                              stop_sel_o, req_sel_o, req_ctl_o, mode_o}));
    // R10: no write, no change
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !we_i |=> $stable({se_en_o, cpu_en_o, src_en_o,
                           stop_sel_o, req_sel_o, req_ctl_o, mode_o}));
endmodule

// File: rtl/clk_gate_chan.sv
`timescale 1ns/1ps
module clk_gate_chan
    import clk_gate_pkg::*;
#(
    parameter ch_kind_e KIND = KIND_CPU
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    fall_i,
    input  ch_ctl_t ctl_i,
    output ch_out_t out_o
);
    ch_state_e state_q;
    ch_state_e state_d;

    always_comb state_d = next_state(KIND, ctl_i);

    always_ff @(posedge clk) begin
        if (rst)         state_q <= CH_FLOAT;
        else if (fall_i) state_q <= state_d;
    end

    always_comb out_o = state_out(state_q);

    // R9: outputs stay coherent
    always_comb begin
        if (!rst) begin
            a_r9_run_hiz_excl: assert (!(out_o.run && out_o.hiz));
            a_r9_hiz_lvl_low:  assert (!(out_o.hiz && out_o.lvl));
        end
    end

    // R7: no strobe, no change
    a_r7_wait_for_fall: assert property (@(posedge clk) disable iff (rst)
        !fall_i |=> $stable(out_o));

    // R2: disable wins over every other condition
    a_r2_disable_floats: assert property (@(posedge clk) disable iff (rst)
        fall_i && !ctl_i.en |=> out_o.hiz && !out_o.run && !out_o.lvl);

    generate
        if (KIND == KIND_SE) begin : g_se_chk
            // R6: single-ended clocks are driven low in power-down
            a_r6_se_pd_low: assert property (@(posedge clk) disable iff (rst)
                fall_i && ctl_i.en && ctl_i.pd |=> !out_o.run && !out_o.hiz && !out_o.lvl);
        end else if (KIND == KIND_CPU) begin : g_cpu_chk
            // R5: stopped and driven pair is held high
            a_r5_stop_drive_high: assert property (@(posedge clk) disable iff (rst)
                fall_i && ctl_i.en && !ctl_i.pd && ctl_i.stop_hit && ctl_i.stop_drive
                |=> !out_o.run && !out_o.hiz && out_o.lvl);
        end else begin : g_src_chk
            // R4: a deasserted governing request floats the pair
            a_r4_req_float: assert property (@(posedge clk) disable iff (rst)
                fall_i && ctl_i.en && !ctl_i.pd && ctl_i.req_float |=> out_o.hiz);
        end
    endgenerate
endmodule

// File: rtl/clk_out_gate.sv
`timescale 1ns/1ps
module clk_out_gate
    import clk_gate_pkg::*;
#(
    parameter int N_CPU      = 3,
    parameter int N_SRC      = 8,
    parameter int N_SE       = 4,
    parameter int SE_48M_IDX = 3,
    parameter int CFG_W      = 8,
    parameter int N_CH       = N_CPU + N_SRC + N_SE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_field,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             cpu_stop_n,
    input  logic [1:0]       clk_req_n,
    input  logic             pwr_dn,
    input  logic [N_CH-1:0]  ch_fall,
    output logic [N_CH-1:0]  ch_run,
    output logic [N_CH-1:0]  ch_stop_lvl,
    output logic [N_CH-1:0]  ch_hiz
);
    localparam int SRC_BASE = N_CPU;
    localparam int SE_BASE  = N_CPU + N_SRC;
    localparam int SYNC_W   = 4;
    // {pwr_dn, clk_req_n[1], clk_req_n[0], cpu_stop_n}: idle is stop released, clocks requested, no power-down
    localparam logic [SYNC_W-1:0] SYNC_RST = 4'b0001;

    logic [N_SE-1:0]  se_en;
    logic [N_CPU-1:0] cpu_en;
    logic [N_SRC-1:0] src_en;
    logic [N_CPU-1:0] stop_sel;
    logic [N_SRC-1:0] req_sel;
    logic [N_SRC-1:0] req_ctl;
    mode_t            mode;

    logic [SYNC_W-1:0] async_in;
    logic [SYNC_W-1:0] sync_out;
    logic              stop_act;
    logic [1:0]        req_hi;
    logic              pd_act;

    ch_out_t ch_out [N_CH];

    clk_gate_cfg #(
        .N_CPU(N_CPU), .N_SRC(N_SRC), .N_SE(N_SE),
        .SE_48M_IDX(SE_48M_IDX), .CFG_W(CFG_W)
    ) u_cfg (
        .clk(clk), .rst(rst),
        .we_i(cfg_we), .field_i(cfg_field), .wdata_i(cfg_wdata),
        .se_en_o(se_en), .cpu_en_o(cpu_en), .src_en_o(src_en),
        .stop_sel_o(stop_sel), .req_sel_o(req_sel), .req_ctl_o(req_ctl),
        .mode_o(mode)
    );

    assign async_in = {pwr_dn, clk_req_n, cpu_stop_n};

    clk_gate_sync #(.W(SYNC_W), .RST_VAL(SYNC_RST)) u_sync (
        .clk(clk), .rst(rst), .d_i(async_in), .q_o(sync_out)
    );

    assign stop_act = ~sync_out[0];
    assign req_hi   = sync_out[2:1];
    assign pd_act   = sync_out[3];

    generate
        for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
            ch_ctl_t c;
            always_comb begin
                c            = '0;
                c.en         = cpu_en[i];
                c.pd         = pd_act;
                c.stop_hit   = stop_act & stop_sel[i];
                c.stop_drive = mode.stop_drive;
                c.pd_drive   = mode.pd_cpu_drive;
            end
            clk_gate_chan #(.KIND(KIND_CPU)) u_ch (
                .clk(clk), .rst(rst), .fall_i(ch_fall[i]), .ctl_i(c), .out_o(ch_out[i])
            );
        end

        for (genvar j = 0; j < N_SRC; j++) begin : g_src
            ch_ctl_t c;
            logic    routed_hi;
            assign routed_hi = req_sel[j] ? req_hi[1] : req_hi[0];
            always_comb begin
                c           = '0;
                c.en        = src_en[j];
                c.pd        = pd_act;
                c.req_float = req_ctl[j] & routed_hi;
                c.pd_drive  = mode.pd_src_drive;
            end
            clk_gate_chan #(.KIND(KIND_SRC)) u_ch (
                .clk(clk), .rst(rst), .fall_i(ch_fall[SRC_BASE+j]), .ctl_i(c),
                .out_o(ch_out[SRC_BASE+j])
            );
        end

        for (genvar k = 0; k < N_SE; k++) begin : g_se
            ch_ctl_t c;
            always_comb begin
                c    = '0;
                c.en = se_en[k];
                c.pd = pd_act;
            end
            clk_gate_chan #(.KIND(KIND_SE)) u_ch (
                .clk(clk), .rst(rst), .fall_i(ch_fall[SE_BASE+k]), .ctl_i(c),
                .out_o(ch_out[SE_BASE+k])
            );
        end

        for (genvar n = 0; n < N_CH; n++) begin : g_pack
            assign ch_run[n]      = ch_out[n].run;
            assign ch_hiz[n]      = ch_out[n].hiz;
            assign ch_stop_lvl[n] = ch_out[n].lvl;
        end
    endgenerate

    // R1: every channel floats directly after reset
    a_r1_reset_float: assert property (@(posedge clk)
        rst |=> (ch_hiz == '1) && (ch_run == '0) && (ch_stop_lvl == '0));
endmodule

// File: tb/clk_out_gate_tb_top.sv
`timescale 1ns/1ps
module clk_out_gate_tb_top;
    localparam int N_CH = 15;
    localparam int NV   = 9;
    localparam logic [N_CH-1:0] ALL = 15'h7FFF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_field = 3'd0;
    logic [7:0] cfg_wdata = 8'd0;
    logic cpu_stop_n = 1'b1;
    logic [1:0] clk_req_n = 2'b00;
    logic pwr_dn = 1'b0;
    logic [N_CH-1:0] ch_fall = '0;
    logic [N_CH-1:0] ch_run, ch_stop_lvl, ch_hiz;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    clk_out_gate dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_field(cfg_field),
        .cfg_wdata(cfg_wdata), .cpu_stop_n(cpu_stop_n), .clk_req_n(clk_req_n),
        .pwr_dn(pwr_dn), .ch_fall(ch_fall), .ch_run(ch_run),
        .ch_stop_lvl(ch_stop_lvl), .ch_hiz(ch_hiz)
    );

    // {mode[2:0], pwr_dn, cpu_stop_n, clk_req_n[1:0], run, hiz, lvl}
    // channels: 0-2 CPU, 3-10 SRC0..7, 11-14 single-ended (14 = 48 MHz)
    localparam logic [51:0] VT [NV] = '{
        {3'b001, 1'b0, 1'b1, 2'b00, 15'h7FFF, 15'h0000, 15'h0000},
        {3'b001, 1'b0, 1'b0, 2'b00, 15'h7FFC, 15'h0000, 15'h0003},
        {3'b001, 1'b0, 1'b1, 2'b01, 15'h7FD7, 15'h0028, 15'h0000},
        {3'b001, 1'b0, 1'b1, 2'b10, 15'h7FAF, 15'h0050, 15'h0000},
        {3'b001, 1'b0, 1'b0, 2'b11, 15'h7F84, 15'h0078, 15'h0003},
        {3'b001, 1'b1, 1'b1, 2'b00, 15'h0000, 15'h07FF, 15'h0000},
        {3'b110, 1'b1, 1'b1, 2'b00, 15'h0000, 15'h0000, 15'h07FF},
        {3'b000, 1'b0, 1'b0, 2'b00, 15'h7FFC, 15'h0003, 15'h0000},
        {3'b001, 1'b0, 1'b1, 2'b00, 15'h7FFF, 15'h0000, 15'h0000}
    };
    localparam string VTAG [NV] = '{"R4", "R5", "R3", "R3", "R4", "R6", "R6", "R5", "R9"};

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cfg_wr(input logic [2:0] f, input logic [7:0] d);
        cfg_we = 1'b1; cfg_field = f; cfg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [N_CH-1:0] er, eh, el);
        n_chk++;
        if (ch_run !== er || ch_hiz !== eh || ch_stop_lvl !== el) begin
            n_err++;
            $display("FAIL %s: run/hiz/lvl actual %h/%h/%h expected %h/%h/%h",
                     tag, ch_run, ch_hiz, ch_stop_lvl, er, eh, el);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst = 1'b0;
        @(negedge clk);
        // R1: floating before any strobe
        chk("R1 pre-strobe", '0, ALL, '0);
        ch_fall = ALL;
        tick(1);
        // R1: 48 MHz channel disabled by default
        chk("R1 defaults", 15'h3FFF, 15'h4000, '0);
        // R1: stop-select defaults to 1, mode 0 floats stopped CPU pairs
        cpu_stop_n = 1'b0;
        tick(4);
        chk("R1 stop-select default", 15'h3FF8, 15'h4007, '0);
        cpu_stop_n = 1'b1;

        cfg_wr(3'd0, 8'h0F);
        cfg_wr(3'd5, 8'h0F);
        cfg_wr(3'd4, 8'h0A);
        cfg_wr(3'd3, 8'h03);
        tick(3);

        for (int v = 0; v < NV; v++) begin
            cfg_wr(3'd6, {5'd0, VT[v][51:49]});
            pwr_dn     = VT[v][48];
            cpu_stop_n = VT[v][47];
            clk_req_n  = VT[v][46:45];
            tick(4);
            chk(VTAG[v], VT[v][44:30], VT[v][29:15], VT[v][14:0]);
        end

        // R10: spare field code changes nothing
        cfg_wr(3'd7, 8'h00);
        clk_req_n = 2'b11;
        tick(4);
        chk("R10 spare field", 15'h7F87, 15'h0078, '0);

        // R3: request-control 0 ignores requests
        cfg_wr(3'd5, 8'h00);
        tick(3);
        chk("R3 ctl off", ALL, '0, '0);
        clk_req_n = 2'b00;

        // R2: disabled channels float under power-down, others held
        cfg_wr(3'd6, 8'h06);
        cfg_wr(3'd1, 8'h06);
        cfg_wr(3'd0, 8'h0E);
        pwr_dn = 1'b1;
        tick(4);
        chk("R2 disable override", '0, 15'h0801, 15'h07FE);

        // R9: resume after power-down
        cfg_wr(3'd1, 8'h07);
        cfg_wr(3'd0, 8'h0F);
        pwr_dn = 1'b0;
        tick(4);
        chk("R9 resume", ALL, '0, '0);

        // R8: latency of exactly three edges (mode bit0 = 0 -> float)
        cpu_stop_n = 1'b0;
        tick(2);
        chk("R8 not before third edge", ALL, '0, '0);
        tick(1);
        chk("R8 at third edge", 15'h7FFC, 15'h0003, '0);
        cpu_stop_n = 1'b1;
        tick(4);

        // R7: no strobe, no change; then per-channel strobe
        ch_fall = '0;
        cpu_stop_n = 1'b0;
        tick(6);
        chk("R7 held without strobe", ALL, '0, '0);
        ch_fall = 15'h0001;
        tick(1);
        chk("R7 one channel strobed", 15'h7FFE, 15'h0001, '0);
        ch_fall = ALL;
        tick(1);
        chk("R7 all strobed", 15'h7FFC, 15'h0003, '0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule